// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block runs the calibration sequence of a sampling converter. A calibration run starts in one of two ways. The first is a rising edge on an active-low calibration pin, which always runs the full self-calibration. The second is a one-cycle start request from the register interface, which carries a mode bit and a two-bit selection. The mode bit picks self or system calibration. The selection picks which phases run and in what order. The phases are internal DAC, gain and offset. Each phase lasts a fixed number of master clock cycles. In its last cycle the phase pulses a write strobe, together with a code that names the coefficient register to be updated.

While a run is in progress the busy output is high. A start-status output reads 1 from the moment a start is accepted, or held back, until the run ends, and then clears on its own. A register start that arrives while a conversion is in progress waits until the conversion ends. Holding the calibration pin low clears all sequencing state at once, and the pin takes priority over every other request.

The phase durations are parameters and sum to 250026 cycles by default. A divide parameter shortens every phase by the same factor, so that simulations stay short.

Top module: `calseq`

## Requirements
- R1: After a synchronous reset, `busy`, `start_bit` and `coef_wr` are 0.
- R2: When the clock edge samples `cal_n` at 1 and the previous sample was 0, a full self-calibration starts: internal DAC, then self gain, then self offset. `busy` goes high in the following cycle.
- R3: With `reg_mode`=0 the selection decodes as follows. `reg_sel` 00 runs DAC, gain, offset. 01 runs gain, offset. 10 runs offset only. 11 runs gain only. The `coef_sel` codes are DAC=0, self gain=1, self offset=2.
- R4: With `reg_mode`=1 the same four orderings apply, but gain is written with code 3 (system gain) and offset with code 4 (system offset). The DAC phase keeps code 0.
- R5: Each phase lasts max(1, floor(C/DIV)) cycles, where C is DAC_CYC, GAIN_CYC or OFFS_CYC. `busy` is high for exactly the sum of the selected phase lengths, starting the cycle after the start is accepted.
- R6: `coef_wr` is high for one cycle, the last cycle of each phase. In that cycle `coef_sel` carries the phase's code.
- R7: While `cal_n` is 0, `busy`, `start_bit` and `coef_wr` are 0 in that same cycle. Any run or held request is dropped, and register starts are ignored.
- R8: A register start that arrives while a calibration is running is ignored. The run in progress continues unchanged.
- R9: A register start that arrives while `conv_busy` is 1 is held. Its calibration begins in the cycle after the first cycle in which `conv_busy` is sampled at 0.
- R10: `start_bit` is 1 while a request is held or a run is in progress, and it falls together with `busy` at the end of the run.
- R11: A rising edge on `cal_n` starts the full self-calibration even while `conv_busy` is 1, and it wins over a register start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_n | input | 1 | Calibration pin: low clears the sequencer, a rising edge starts a full self-calibration |
| reg_start | input | 1 | One-cycle start request from the register interface |
| reg_mode | input | 1 | 0 = self calibration, 1 = system calibration |
| reg_sel | input | 2 | Selection of the phase list |
| conv_busy | input | 1 | High while a conversion is in progress |
| busy | output | 1 | High for the whole calibration run |
| start_bit | output | 1 | Start-calibration status, cleared automatically at the end of a run |
| coef_wr | output | 1 | One-cycle write strobe at the end of each phase |
| coef_sel | output | 3 | Coefficient register addressed by `coef_wr` |

## Verification
Suppose the phase counter or the phase index holds a wrong value. The run then has the wrong length, and `busy` falls early or late, or the strobe lands on a wrong cycle or carries a wrong `coef_sel`. A per-clock reference model exposes this on the very cycle it happens. A held request that is lost shows up as `start_bit` dropping while no `busy` follows. A request that was wrongly accepted raises `busy` on a cycle where the model keeps it low. Both are seen one cycle after the offending input. Every selection and mode is run, together with aborts by the pin and starts that are held during a conversion.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

    typedef enum logic [1:0] {
        PH_DAC  = 2'd0,
        PH_GAIN = 2'd1,
        PH_OFFS = 2'd2
    } phase_e;

    // Coefficient register codes (R3, R4)
    typedef enum logic [2:0] {
        CO_DAC   = 3'd0,
        CO_SGAIN = 3'd1,
        CO_SOFFS = 3'd2,
        CO_YGAIN = 3'd3,
        CO_YOFFS = 3'd4
    } coef_e;

    typedef struct packed {
        logic         mode;   // 1 = system calibration
        logic [1:0]   last;   // index of the final phase
        phase_e [2:0] ph;     // ordered phase list
    } plan_t;

    function automatic plan_t decode_plan(input logic mode, input logic [1:0] sel);
        plan_t p;
        p       = '0;
        p.mode  = mode;
        p.ph[0] = PH_OFFS;
        p.ph[1] = PH_OFFS;
        p.ph[2] = PH_OFFS;
        case (sel)
            2'b00: begin
                p.last  = 2'd2;
                p.ph[0] = PH_DAC;
                p.ph[1] = PH_GAIN;
                p.ph[2] = PH_OFFS;
            end
            2'b01: begin
                p.last  = 2'd1;
                p.ph[0] = PH_GAIN;
                p.ph[1] = PH_OFFS;
            end
            2'b10: begin
                p.last  = 2'd0;
                p.ph[0] = PH_OFFS;
            end
            default: begin
                p.last  = 2'd0;
                p.ph[0] = PH_GAIN;
            end
        endcase
        return p;
    endfunction

    function automatic coef_e coef_of(input phase_e ph, input logic mode);
        case (ph)
            PH_DAC:  return CO_DAC;
            PH_GAIN: return mode ? CO_YGAIN : CO_SGAIN;
            default: return mode ? CO_YOFFS : CO_SOFFS;
        endcase
    endfunction

    function automatic int unsigned scaled_len(input int unsigned cyc, input int unsigned div);
        int unsigned q;
        q = cyc / div;
        return (q == 0) ? 1 : q;
    endfunction

endpackage

// File: rtl/calseq_req.sv
module calseq_req
    import calseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cal_n,
    input  logic       reg_start,
    input  logic       reg_mode,
    input  logic [1:0] reg_sel,
    input  logic       conv_busy,
    input  logic       running,
    output logic       start,
    output plan_t      plan,
    output logic       pending
);

    logic       cal_q;
    logic       pend_q;
    logic       pmode_q;
    logic [1:0] psel_q;
    logic       rise;
    logic       want;
    logic       reg_go;

    assign rise   = cal_n & ~cal_q;
    assign want   = (reg_start | pend_q) & cal_n & ~rise & ~running;
    assign reg_go = want & ~conv_busy;
    assign start  = rise | reg_go;

    always_comb begin
        if (rise)
            plan = decode_plan(1'b0, 2'b00);
        else if (reg_start)
            plan = decode_plan(reg_mode, reg_sel);
        else
            plan = decode_plan(pmode_q, psel_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q   <= 1'b1;
            pend_q  <= 1'b0;
            pmode_q <= 1'b0;
            psel_q  <= 2'b00;
        end else begin
            cal_q <= cal_n;
            if (!cal_n || rise || reg_go) begin
                pend_q <= 1'b0;
            end else if (reg_start && !running && conv_busy) begin
                pend_q  <= 1'b1;
                pmode_q <= reg_mode;
                psel_q  <= reg_sel;
            end
        end
    end

    assign pending = pend_q;

    // R9: a held request survives while the conversion continues
    a_r9_hold_during_conv: assert property (@(posedge clk) disable iff (rst)
        pend_q && conv_busy && cal_n |=> pend_q);

    // R7: a low calibration pin drops a held request
    a_r7_pin_drops_request: assert property (@(posedge clk) disable iff (rst)
        !cal_n |=> !pend_q);

    // R8: no start is accepted while a run is in progress
    a_r8_no_start_running: assert property (@(posedge clk) disable iff (rst)
        running |-> !start);

endmodule

// File: rtl/calseq_step.sv
module calseq_step
    import calseq_pkg::*;
#(
    parameter int unsigned LEN_DAC  = 27,
    parameter int unsigned LEN_GAIN = 194,
    parameter int unsigned LEN_OFFS = 27
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  abort,
    input  logic  start,
    input  plan_t plan,
    output logic  running,
    output logic  phase_end,
    output coef_e coef
);

    localparam int unsigned LMAX1 = (LEN_DAC > LEN_GAIN) ? LEN_DAC : LEN_GAIN;
    localparam int unsigned LMAX  = (LMAX1 > LEN_OFFS) ? LMAX1 : LEN_OFFS;
    localparam int unsigned CW    = $clog2(LMAX + 1);

    logic          run_q;
    logic [1:0]    idx_q;
    logic [CW-1:0] cnt_q;
    plan_t         plan_q;
    phase_e        cur;
    phase_e        nxt;

    function automatic logic [CW-1:0] load_of(input phase_e ph);
        case (ph)
            PH_DAC:  return CW'(LEN_DAC - 1);
            PH_GAIN: return CW'(LEN_GAIN - 1);
            default: return CW'(LEN_OFFS - 1);
        endcase
    endfunction

    assign cur = plan_q.ph[idx_q];
    assign nxt = plan_q.ph[idx_q + 2'd1];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            idx_q  <= 2'd0;
            cnt_q  <= '0;
            plan_q <= '0;
        end else if (abort) begin
            run_q <= 1'b0;
        end else if (start) begin
            run_q  <= 1'b1;
            idx_q  <= 2'd0;
            plan_q <= plan;
            cnt_q  <= load_of(plan.ph[0]);
        end else if (run_q) begin
            if (cnt_q == '0) begin
                if (idx_q == plan_q.last) begin
                    run_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 2'd1;
                    cnt_q <= load_of(nxt);
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign running   = run_q;
    assign phase_end = run_q & (cnt_q == '0);
    assign coef      = coef_of(cur, plan_q.mode);

    // R5: the phase counter steps down by one each cycle
    a_r5_countdown: assert property (@(posedge clk) disable iff (rst)
        run_q && !abort && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);

    // R7: the pin abort stops a run on the next cycle
    a_r7_abort_stops: assert property (@(posedge clk) disable iff (rst)
        abort |=> !run_q);

    // R2: an accepted start enters the first phase
    a_r2_start_enters: assert property (@(posedge clk) disable iff (rst)
        start && !abort |=> run_q && idx_q == 2'd0);

    // R6: the end of a phase that is not the last advances the index
    a_r6_phase_advance: assert property (@(posedge clk) disable iff (rst)
        run_q && !abort && !start && cnt_q == '0 && idx_q != plan_q.last
        |=> run_q && idx_q == $past(idx_q) + 2'd1);

endmodule

// File: rtl/calseq.sv
module calseq
    import calseq_pkg::*;
#(
    parameter int unsigned DAC_CYC  = 27798,
    parameter int unsigned GAIN_CYC = 194430,
    parameter int unsigned OFFS_CYC = 27798,
    parameter int unsigned DIV      = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cal_n,
    input  logic       reg_start,
    input  logic       reg_mode,
    input  logic [1:0] reg_sel,
    input  logic       conv_busy,
    output logic       busy,
    output logic       start_bit,
    output logic       coef_wr,
    output logic [2:0] coef_sel
);

    localparam int unsigned L_DAC  = scaled_len(DAC_CYC, DIV);
    localparam int unsigned L_GAIN = scaled_len(GAIN_CYC, DIV);
    localparam int unsigned L_OFFS = scaled_len(OFFS_CYC, DIV);

    logic  start;
    plan_t plan;
    logic  pending;
    logic  running;
    logic  phase_end;
    coef_e coef;

    calseq_req u_req (
        .clk       (clk),
        .rst       (rst),
        .cal_n     (cal_n),
        .reg_start (reg_start),
        .reg_mode  (reg_mode),
        .reg_sel   (reg_sel),
        .conv_busy (conv_busy),
        .running   (running),
        .start     (start),
        .plan      (plan),
        .pending   (pending)
    );

    calseq_step #(
        .LEN_DAC  (L_DAC),
        .LEN_GAIN (L_GAIN),
        .LEN_OFFS (L_OFFS)
    ) u_step (
        .clk       (clk),
        .rst       (rst),
        .abort     (~cal_n),
        .start     (start),
        .plan      (plan),
        .running   (running),
        .phase_end (phase_end),
        .coef      (coef)
    );

    assign busy      = running & cal_n;
    assign start_bit = (running | pending) & cal_n;
    assign coef_wr   = phase_end & cal_n;
    assign coef_sel  = coef;

    // R10: the status bit covers the whole busy window
    a_r10_status_covers_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> start_bit);

    // R10: the status bit clears when the run ends with nothing held
    a_r10_status_clears: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) && cal_n && !pending |-> !start_bit);

    // R1: outputs are quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !busy && !coef_wr);

endmodule

// File: tb/tb_calseq.sv
module tb_calseq;

    localparam int CLK_P    = 10;
    localparam int DAC_CYC  = 27798;
    localparam int GAIN_CYC = 194430;
    localparam int OFFS_CYC = 27798;
    localparam int DIV      = 1000;

    localparam int LD = (DAC_CYC / DIV == 0) ? 1 : DAC_CYC / DIV;
    localparam int LG = (GAIN_CYC / DIV == 0) ? 1 : GAIN_CYC / DIV;
    localparam int LO = (OFFS_CYC / DIV == 0) ? 1 : OFFS_CYC / DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cal_n = 1'b1;
    logic       reg_start = 1'b0;
    logic       reg_mode = 1'b0;
    logic [1:0] reg_sel = 2'b00;
    logic       conv_busy = 1'b0;
    logic       busy;
    logic       start_bit;
    logic       coef_wr;
    logic [2:0] coef_sel;

    calseq #(
        .DAC_CYC  (DAC_CYC),
        .GAIN_CYC (GAIN_CYC),
        .OFFS_CYC (OFFS_CYC),
        .DIV      (DIV)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .cal_n     (cal_n),
        .reg_start (reg_start),
        .reg_mode  (reg_mode),
        .reg_sel   (reg_sel),
        .conv_busy (conv_busy),
        .busy      (busy),
        .start_bit (start_bit),
        .coef_wr   (coef_wr),
        .coef_sel  (coef_sel)
    );

    always #(CLK_P / 2) clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    live = 1'b0;
    string ctx = "R1 reset";

    // reference model state
    bit m_run = 0;
    bit m_pend = 0;
    bit m_calq = 1;
    bit m_pm = 0;
    bit [1:0] m_ps = 0;
    int m_cnt = 0;
    int q_code[$];
    bit m_rise;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] act=%0d exp=%0d t=%0t", tag, ctx, act, exp, $time);
        end
    endtask

    function automatic int lenof(input int c);
        if (c == 0) return LD;
        if (c == 1 || c == 3) return LG;
        return LO;
    endfunction

    task automatic m_load(input bit md, input bit [1:0] s);
        int g, o;
        g = md ? 3 : 1;
        o = md ? 4 : 2;
        q_code.delete();
        case (s)
            2'd0: begin q_code.push_back(0); q_code.push_back(g); q_code.push_back(o); end
            2'd1: begin q_code.push_back(g); q_code.push_back(o); end
            2'd2: q_code.push_back(o);
            default: q_code.push_back(g);
        endcase
        m_run = 1;
        m_cnt = lenof(q_code[0]) - 1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_pend = 0; m_calq = 1; m_pm = 0; m_ps = 0; m_cnt = 0;
            q_code.delete();
        end else begin
            m_rise = cal_n && !m_calq;
            m_calq = cal_n;
            if (!cal_n) begin
                m_run = 0; m_pend = 0; q_code.delete();
            end else if (m_rise) begin
                m_pend = 0;
                m_load(1'b0, 2'b00);
            end else if (m_run) begin
                if (m_cnt == 0) begin
                    void'(q_code.pop_front());
                    if (q_code.size() == 0) m_run = 0;
                    else m_cnt = lenof(q_code[0]) - 1;
                end else begin
                    m_cnt--;
                end
            end else if (reg_start || m_pend) begin
                if (conv_busy) begin
                    if (reg_start) begin
                        m_pend = 1; m_pm = reg_mode; m_ps = reg_sel;
                    end
                end else begin
                    if (reg_start) m_load(reg_mode, reg_sel);
                    else m_load(m_pm, m_ps);
                    m_pend = 0;
                end
            end
        end
        live = 1'b1;
        #(CLK_P / 4);
        begin
            bit eb, ew, es;
            eb = m_run && cal_n;
            ew = m_run && (m_cnt == 0) && cal_n;
            es = (m_run || m_pend) && cal_n;
            chk("R5 busy", busy, eb);
            chk("R10 start_bit", start_bit, es);
            chk("R6 coef_wr", coef_wr, ew);
            if (ew) chk("R3 coef_sel", coef_sel, q_code[0]);
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog R5 act=%0d exp=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_req(input bit md, input bit [1:0] s);
        @(negedge clk);
        reg_start = 1'b1; reg_mode = md; reg_sel = s;
        @(negedge clk);
        reg_start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!m_run && !m_pend) break;
        end
        idle(3);
    endtask

    initial begin
        idle(3);
        chk("R1 busy after reset", busy, 0);
        chk("R1 start_bit after reset", start_bit, 0);
        chk("R1 coef_wr after reset", coef_wr, 0);
        rst = 1'b0;
        idle(2);

        ctx = "R2 pin start";
        cal_n = 1'b0; idle(1); cal_n = 1'b1;
        idle(2);
        chk("R2 busy after rising edge", busy, 1);
        wait_done();

        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                ctx = (md == 0) ? "R3 self list" : "R4 system list";
                reg_req(md[0], s[1:0]);
                wait_done();
            end
        end

        ctx = "R9 held during conversion";
        conv_busy = 1'b1;
        reg_req(1'b1, 2'b10);
        idle(4);
        chk("R9 busy held off", busy, 0);
        chk("R9 start_bit while held", start_bit, 1);
        conv_busy = 1'b0;
        idle(2);
        chk("R9 busy after release", busy, 1);
        wait_done();

        ctx = "R8 start while running";
        reg_req(1'b0, 2'b11);
        idle(10);
        reg_req(1'b1, 2'b00);
        wait_done();

        ctx = "R7 pin abort";
        reg_req(1'b0, 2'b00);
        idle(50);
        cal_n = 1'b0;
        #1;
        chk("R7 busy while pin low", busy, 0);
        idle(1);
        reg_start = 1'b1; reg_mode = 1'b1; reg_sel = 2'b01;
        idle(1);
        reg_start = 1'b0;
        idle(1);
        chk("R7 start_bit while pin low", start_bit, 0);
        cal_n = 1'b1;
        wait_done();

        ctx = "R11 pin over conversion and request";
        conv_busy = 1'b1;
        reg_req(1'b1, 2'b01);
        idle(2);
        cal_n = 1'b0;
        idle(2);
        cal_n = 1'b1; reg_start = 1'b1; reg_mode = 1'b1; reg_sel = 2'b11;
        idle(1);
        reg_start = 1'b0;
        idle(1);
        chk("R11 busy despite conversion", busy, 1);
        idle(5);
        conv_busy = 1'b0;
        wait_done();

        ctx = "R9 release same cycle";
        conv_busy = 1'b1;
        @(negedge clk);
        reg_start = 1'b1; reg_mode = 1'b0; reg_sel = 2'b10;
        conv_busy = 1'b0;
        @(negedge clk);
        reg_start = 1'b0;
        wait_done();

        summary();
        $finish;
    end

endmodule